// File: doc/BRIEF.md
# Triggered Window Recorder

The block stores a stream of byte samples into a memory region that software divides into equal windows. Each window is filled from its own start address. In wrap mode the fill pointer loops inside the window until a trigger arrives. The trigger sample and a programmed number of later samples finish the window, and recording moves on to the next window. In linear mode a window also closes once its last address is written. For each window the block keeps a saturating sample count, a trigger flag, the address of the newest sample, and the 64-bit timestamp that came with the trigger.

Software sets up the region and the modes through a small word-addressed register port. It collects finished windows when the interrupt line rises. If the block runs without the overwrite option, a window that still holds unread data blocks recording until software clears that window's count. Samples that arrive during this wait are dropped.

Global registers sit at `reg_addr_i[5]=0` and are selected by `reg_addr_i[2:0]`: 0 control, 1 base address, 2 window size in bytes, 3 window count, 4 post-trigger samples, 5 interrupt flag, 6 current window (read only), 7 last closed window (read only). Control bits are: bit0 enable, bit1 interrupt enable, bit2 wrap mode, bit3 overwrite. Per-window registers sit at `reg_addr_i[5]=1`, with the window in `[4:2]` and the field in `[1:0]`: 0 count, with the trigger flag in bit31 (a write clears both), 1 last address, 2 timestamp low word, 3 timestamp high word.

Top module: `win_recorder`

## Requirements
- R1: After reset, irq_o and mem_we_o are low. Control reads 0, the current window and last window read 0, and every window count and last address read 0.
- R2: Each accepted sample (valid high, enabled, not held) appears on the memory port one cycle later. The first sample of window k goes to base + k*size, and each later sample goes to the next byte address.
- R3: In wrap mode (control bit2=1), a write at the window's last address is followed by a write at the window's first address. The window count saturates at the window size, and the last-address field holds the address of the newest sample.
- R4: A trigger sample (trigger and valid high) latches smp_ts_i into the window's timestamp and sets bit31 of its count register. The window closes on the post-trigger-count-th later accepted sample. Triggers during this countdown are ignored. The next window index is (current+1) modulo the window count, and the last-window register takes the closed index.
- R5: In linear mode (control bit2=0), a window closes after the sample written at its last address.
- R6: With overwrite off (control bit3=0), entering a window whose count is non-zero drops all samples until software writes that window's count register. After the write, recording restarts at the window start with a count of 1.
- R7: With overwrite on (control bit3=1), the first sample in a newly entered window restarts its count at 1 and clears its trigger flag, whatever the previous contents.
- R8: A window close with interrupt enable set (control bit1=1) sets the interrupt flag (register 5, bit0), and irq_o follows the flag. Writing 1 to bit0 clears it. With interrupt enable clear, closes raise no interrupt.
- R9: With enable clear (control bit0=0), samples produce no memory write and change no window state.
- R10: A window count of 0 is stored as 1, and a value above the maximum number of windows is stored as that maximum.
- R11: A trigger presented while valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample valid |
| smp_trig_i | input | 1 | Trigger, qualified by valid |
| smp_data_i | input | 8 | Sample byte |
| smp_ts_i | input | 64 | Timestamp accompanying the sample |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_data_o | output | 8 | Memory write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Window-complete interrupt |

## Verification
The checks assume that software changes base, size and window count only while no write is in flight. They also assume the window count is never lowered below the current index and the window size is never set under the counts already stored. Under these assumptions every write lands inside the buffer and the current index stays in range. The stimulus therefore reconfigures only right after reset or while the sample input is idle. It uses non-zero sizes and switches only the mode bits in the middle of a run, so the range and saturation properties hold throughout.

// File: rtl/win_rec_pkg.sv
package win_rec_pkg;
  typedef struct packed {
    logic ovwr;
    logic ring;
    logic irq_en;
    logic en;
  } rec_ctrl_t;

  localparam logic [2:0] G_CTRL = 3'd0;
  localparam logic [2:0] G_BASE = 3'd1;
  localparam logic [2:0] G_SIZE = 3'd2;
  localparam logic [2:0] G_NWIN = 3'd3;
  localparam logic [2:0] G_POST = 3'd4;
  localparam logic [2:0] G_IRQ  = 3'd5;
  localparam logic [2:0] G_CUR  = 3'd6;
  localparam logic [2:0] G_LAST = 3'd7;

  localparam logic [1:0] W_CNT  = 2'd0;
  localparam logic [1:0] W_ADDR = 2'd1;
  localparam logic [1:0] W_TSLO = 2'd2;
  localparam logic [1:0] W_TSHI = 2'd3;
endpackage

// File: rtl/win_rec_regs.sv
module win_rec_regs
  import win_rec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int WIN_MAX = 4,
  parameter int REG_AW  = 6,
  parameter int IDX_W   = 2,
  parameter int NW_W    = 3,
  parameter int RW_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              close_i,
  input  logic [IDX_W-1:0]  cur_idx_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  input  logic              rd_trg_i,
  input  logic [ADDR_W-1:0] rd_last_i,
  input  logic [63:0]       rd_ts_i,
  output logic [RW_W-1:0]   rd_idx_o,
  output logic              clr_o,
  output logic [RW_W-1:0]   clr_idx_o,
  output rec_ctrl_t         ctrl_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  size_o,
  output logic [NW_W-1:0]   nwin_o,
  output logic [CNT_W-1:0]  post_o,
  output logic              irq_o
);
  logic       is_win;
  logic [2:0] gsel;
  logic [1:0] wsel;
  logic       irq_q;

  assign is_win    = reg_addr_i[5];
  assign gsel      = reg_addr_i[2:0];
  assign wsel      = reg_addr_i[1:0];
  assign rd_idx_o  = reg_addr_i[RW_W+1:2];
  assign clr_idx_o = reg_addr_i[RW_W+1:2];
  assign clr_o     = reg_we_i && is_win && (wsel == W_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      base_o <= '0;
      size_o <= CNT_W'(16);
      nwin_o <= NW_W'(WIN_MAX);
      post_o <= '0;
    end else if (reg_we_i && !is_win) begin
      case (gsel)
        G_CTRL: ctrl_o <= rec_ctrl_t'(reg_wdata_i[3:0]);
        G_BASE: base_o <= reg_wdata_i[ADDR_W-1:0];
        G_SIZE: size_o <= reg_wdata_i[CNT_W-1:0];
        G_NWIN: begin
          if (reg_wdata_i == 32'd0)                nwin_o <= NW_W'(1);
          else if (reg_wdata_i > 32'(WIN_MAX))     nwin_o <= NW_W'(WIN_MAX);
          else                                     nwin_o <= reg_wdata_i[NW_W-1:0];
        end
        G_POST: post_o <= reg_wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (close_i && ctrl_o.irq_en) irq_q <= 1'b1;
    else if (reg_we_i && !is_win && gsel == G_IRQ && reg_wdata_i[0]) irq_q <= 1'b0;
  end
  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    if (!is_win) begin
      case (gsel)
        G_CTRL: reg_rdata_o = 32'(ctrl_o);
        G_BASE: reg_rdata_o = 32'(base_o);
        G_SIZE: reg_rdata_o = 32'(size_o);
        G_NWIN: reg_rdata_o = 32'(nwin_o);
        G_POST: reg_rdata_o = 32'(post_o);
        G_IRQ:  reg_rdata_o = 32'(irq_q);
        G_CUR:  reg_rdata_o = 32'(cur_idx_i);
        G_LAST: reg_rdata_o = 32'(last_idx_i);
        default: ;
      endcase
    end else begin
      case (wsel)
        W_CNT:  reg_rdata_o = {rd_trg_i, 31'(rd_cnt_i)};
        W_ADDR: reg_rdata_o = 32'(rd_last_i);
        W_TSLO: reg_rdata_o = rd_ts_i[31:0];
        W_TSHI: reg_rdata_o = rd_ts_i[63:32];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/win_rec_core.sv
module win_rec_core
  import win_rec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2,
  parameter int NW_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rec_ctrl_t         ctrl_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic [NW_W-1:0]   nwin_i,
  input  logic [CNT_W-1:0]  post_i,
  input  logic              vld_i,
  input  logic              trig_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_cur_i,
  output logic              acc_o,
  output logic              restart_o,
  output logic              trig_acc_o,
  output logic              close_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic [IDX_W-1:0]  last_idx_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [ADDR_W-1:0] ptr_q, win_start, win_end;
  logic [CNT_W-1:0]  remain_q;
  logic              fresh_q, armed_q;
  logic              hold, at_end, post_done;
  logic [NW_W:0]     inc;
  logic [IDX_W-1:0]  next_idx;

  assign win_start = base_i + ADDR_W'(cur_idx_o) * ADDR_W'(size_i);
  assign win_end   = win_start + ADDR_W'(size_i) - ADDR_W'(1);

  // a fresh window with unread data blocks when overwrite is off
  assign hold       = fresh_q && !ctrl_i.ovwr && (cnt_cur_i != '0);
  assign acc_o      = ctrl_i.en && vld_i && !hold;
  assign restart_o  = acc_o && fresh_q;
  assign wr_addr_o  = fresh_q ? win_start : ptr_q;
  assign at_end     = (wr_addr_o == win_end);
  assign trig_acc_o = acc_o && trig_i && !armed_q;
  assign post_done  = (armed_q && acc_o && remain_q == CNT_W'(1)) ||
                      (trig_acc_o && post_i == '0);
  assign close_o    = post_done || (acc_o && !ctrl_i.ring && at_end);

  assign inc      = (NW_W+1)'(cur_idx_o) + (NW_W+1)'(1);
  assign next_idx = (inc >= {1'b0, nwin_i}) ? '0 : IDX_W'(inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_idx_o  <= '0;
      last_idx_o <= '0;
      fresh_q    <= 1'b1;
      armed_q    <= 1'b0;
      remain_q   <= '0;
      ptr_q      <= '0;
    end else if (close_o) begin
      last_idx_o <= cur_idx_o;
      cur_idx_o  <= next_idx;
      fresh_q    <= 1'b1;
      armed_q    <= 1'b0;
    end else if (acc_o) begin
      fresh_q <= 1'b0;
      ptr_q   <= at_end ? win_start : wr_addr_o + ADDR_W'(1);
      if (trig_acc_o) begin
        armed_q  <= 1'b1;
        remain_q <= post_i;
      end else if (armed_q) begin
        remain_q <= remain_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= acc_o;
      if (acc_o) begin
        mem_addr_o <= wr_addr_o;
        mem_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/win_rec_store.sv
module win_rec_store #(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int WIN_MAX = 4,
  parameter int IDX_W   = 2,
  parameter int RW_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  size_i,
  input  logic [IDX_W-1:0]  cur_idx_i,
  input  logic              acc_i,
  input  logic              restart_i,
  input  logic              trig_acc_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [63:0]       ts_i,
  input  logic              clr_i,
  input  logic [RW_W-1:0]   clr_idx_i,
  input  logic [RW_W-1:0]   rd_idx_i,
  output logic [CNT_W-1:0]  cnt_cur_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              rd_trg_o,
  output logic [ADDR_W-1:0] rd_last_o,
  output logic [63:0]       rd_ts_o
);
  logic [CNT_W-1:0]  cnt_a  [WIN_MAX];
  logic              trg_a  [WIN_MAX];
  logic [ADDR_W-1:0] last_a [WIN_MAX];
  logic [63:0]       ts_a   [WIN_MAX];

  for (genvar w = 0; w < WIN_MAX; w++) begin : g_win
    logic [CNT_W-1:0]  cnt_q;
    logic              trg_q;
    logic [ADDR_W-1:0] last_q;
    logic [63:0]       ts_q;
    logic              sel;

    assign sel = (32'(cur_idx_i) == w);

    // hardware update takes priority over a software clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        trg_q  <= 1'b0;
        last_q <= '0;
        ts_q   <= '0;
      end else if (acc_i && sel) begin
        last_q <= wr_addr_i;
        if (restart_i) begin
          cnt_q <= CNT_W'(1);
          trg_q <= trig_acc_i;
        end else begin
          cnt_q <= (cnt_q >= size_i) ? size_i : cnt_q + CNT_W'(1);
          trg_q <= trg_q | trig_acc_i;
        end
        if (trig_acc_i) ts_q <= ts_i;
      end else if (clr_i && 32'(clr_idx_i) == w) begin
        cnt_q <= '0;
        trg_q <= 1'b0;
      end
    end

    assign cnt_a[w]  = cnt_q;
    assign trg_a[w]  = trg_q;
    assign last_a[w] = last_q;
    assign ts_a[w]   = ts_q;
  end

  assign cnt_cur_o = cnt_a[cur_idx_i];

  always_comb begin
    rd_cnt_o  = '0;
    rd_trg_o  = 1'b0;
    rd_last_o = '0;
    rd_ts_o   = '0;
    if (32'(rd_idx_i) < WIN_MAX) begin
      rd_cnt_o  = cnt_a[rd_idx_i[IDX_W-1:0]];
      rd_trg_o  = trg_a[rd_idx_i[IDX_W-1:0]];
      rd_last_o = last_a[rd_idx_i[IDX_W-1:0]];
      rd_ts_o   = ts_a[rd_idx_i[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/win_recorder.sv
module win_recorder
  import win_rec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8,
  parameter int WIN_MAX = 4,
  parameter int REG_AW  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic              smp_trig_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [63:0]       smp_ts_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = (WIN_MAX > 1) ? $clog2(WIN_MAX) : 1;
  localparam int NW_W  = $clog2(WIN_MAX + 1);
  localparam int RW_W  = REG_AW - 3;

  rec_ctrl_t         ctrl;
  logic [ADDR_W-1:0] base, wr_addr, rd_last;
  logic [CNT_W-1:0]  size, post, cnt_cur, rd_cnt;
  logic [NW_W-1:0]   nwin;
  logic [IDX_W-1:0]  cur_idx, last_idx;
  logic [RW_W-1:0]   rd_idx, clr_idx;
  logic              acc, restart, trig_acc, win_close, clr, rd_trg;
  logic [63:0]       rd_ts;

  win_rec_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_MAX(WIN_MAX), .REG_AW(REG_AW),
    .IDX_W(IDX_W), .NW_W(NW_W), .RW_W(RW_W)
  ) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .close_i(win_close), .cur_idx_i(cur_idx), .last_idx_i(last_idx),
    .rd_cnt_i(rd_cnt), .rd_trg_i(rd_trg), .rd_last_i(rd_last), .rd_ts_i(rd_ts),
    .rd_idx_o(rd_idx), .clr_o(clr), .clr_idx_o(clr_idx),
    .ctrl_o(ctrl), .base_o(base), .size_o(size), .nwin_o(nwin), .post_o(post),
    .irq_o
  );

  win_rec_core #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .NW_W(NW_W)
  ) u_core (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .base_i(base), .size_i(size), .nwin_i(nwin),
    .post_i(post), .vld_i(smp_vld_i), .trig_i(smp_trig_i), .data_i(smp_data_i),
    .cnt_cur_i(cnt_cur), .acc_o(acc), .restart_o(restart), .trig_acc_o(trig_acc),
    .close_o(win_close), .wr_addr_o(wr_addr), .cur_idx_o(cur_idx),
    .last_idx_o(last_idx), .mem_we_o, .mem_addr_o, .mem_data_o
  );

  win_rec_store #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_MAX(WIN_MAX), .IDX_W(IDX_W), .RW_W(RW_W)
  ) u_store (
    .clk_i, .rst_ni, .size_i(size), .cur_idx_i(cur_idx), .acc_i(acc),
    .restart_i(restart), .trig_acc_i(trig_acc), .wr_addr_i(wr_addr),
    .ts_i(smp_ts_i), .clr_i(clr), .clr_idx_i(clr_idx), .rd_idx_i(rd_idx),
    .cnt_cur_o(cnt_cur), .rd_cnt_o(rd_cnt), .rd_trg_o(rd_trg),
    .rd_last_o(rd_last), .rd_ts_o(rd_ts)
  );
endmodule

// File: rtl/win_rec_checker.sv
module win_rec_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2,
  parameter int NW_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] base,
  input logic [CNT_W-1:0]  size,
  input logic [NW_W-1:0]   nwin,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [CNT_W-1:0]  cnt_cur,
  input logic              win_close,
  input logic              irq
);
  a_r2_addr_in_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (32'(mem_addr) >= 32'(base)) &&
               (32'(mem_addr) < 32'(base) + 32'(nwin) * 32'(size)));

  a_r3_count_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_cur <= size);

  a_r4_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cur_idx) < 32'(nwin));

  a_r4_next_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_close |=> (32'(cur_idx) ==
      ((32'($past(cur_idx)) + 1 >= 32'(nwin)) ? 0 : 32'($past(cur_idx)) + 1)));

  a_r8_irq_needs_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq) |-> $past(win_close));

  a_r9_disabled_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !mem_we);
endmodule

bind win_recorder win_rec_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .NW_W(NW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(ctrl.en), .mem_we(mem_we_o),
  .mem_addr(mem_addr_o), .base(base), .size(size), .nwin(nwin),
  .cur_idx(cur_idx), .cnt_cur(cnt_cur), .win_close(win_close), .irq(irq_o)
);

// File: tb/win_recorder_test.sv
module win_recorder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, trig = 1'b0;
  logic [7:0]  data = '0;
  logic [63:0] ts = '0;
  logic        we;
  logic [15:0] addr;
  logic [7:0]  wdat;
  logic        r_we = 1'b0;
  logic [5:0]  r_addr = '0;
  logic [31:0] r_wdata = '0, r_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  win_recorder uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_trig_i(trig),
    .smp_data_i(data), .smp_ts_i(ts), .mem_we_o(we), .mem_addr_o(addr),
    .mem_data_o(wdat), .reg_we_i(r_we), .reg_addr_i(r_addr),
    .reg_wdata_i(r_wdata), .reg_rdata_o(r_rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic       vld;
    logic       trig;
    logic [7:0] data;
    logic       we;
    logic [15:0] addr;
    logic       irq;
  } vec_t;

  // wrap mode, base 0x100, size 8, 3 windows, 2 post-trigger samples
  localparam vec_t VECS [16] = '{
    '{1'b1,1'b0,8'd0 ,1'b1,16'h0100,1'b0},
    '{1'b1,1'b0,8'd1 ,1'b1,16'h0101,1'b0},
    '{1'b1,1'b0,8'd2 ,1'b1,16'h0102,1'b0},
    '{1'b1,1'b0,8'd3 ,1'b1,16'h0103,1'b0},
    '{1'b1,1'b0,8'd4 ,1'b1,16'h0104,1'b0},
    '{1'b1,1'b0,8'd5 ,1'b1,16'h0105,1'b0},
    '{1'b1,1'b0,8'd6 ,1'b1,16'h0106,1'b0},
    '{1'b1,1'b0,8'd7 ,1'b1,16'h0107,1'b0},
    '{1'b1,1'b0,8'd8 ,1'b1,16'h0100,1'b0},
    '{1'b1,1'b0,8'd9 ,1'b1,16'h0101,1'b0},
    '{1'b0,1'b1,8'hAA,1'b0,16'h0000,1'b0},
    '{1'b1,1'b1,8'd10,1'b1,16'h0102,1'b0},
    '{1'b1,1'b1,8'd11,1'b1,16'h0103,1'b0},
    '{1'b1,1'b0,8'd12,1'b1,16'h0104,1'b1},
    '{1'b1,1'b0,8'd13,1'b1,16'h0108,1'b1},
    '{1'b1,1'b0,8'd14,1'b1,16'h0109,1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    r_we = 1'b1; r_addr = a; r_wdata = d;
    @(negedge clk);
    r_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    r_addr = a;
    #1;
    d = r_rdata;
  endtask

  task automatic smp(input logic v, input logic t, input logic [7:0] d);
    vld = v; trig = t; data = d;
    @(negedge clk);
    vld = 1'b0; trig = 1'b0;
  endtask

  task automatic smp_chk(input string req, input logic t, input logic [7:0] d,
                         input logic ewe, input logic [15:0] ea);
    smp(1'b1, t, d);
    chk(req, 32'(we), 32'(ewe));
    if (ewe) begin
      chk(req, 32'(addr), 32'(ea));
      chk(req, 32'(wdat), 32'(d));
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 we", 32'(we), 0);
    reg_rd(6'h00, rv); chk("R1 ctrl", rv, 0);
    reg_rd(6'h06, rv); chk("R1 cur", rv, 0);

    reg_wr(6'h01, 32'h100);
    reg_wr(6'h02, 32'd8);
    reg_wr(6'h03, 32'd3);
    reg_wr(6'h04, 32'd2);
    reg_wr(6'h00, 32'hF);

    // table: R2 R3 R4 R8 R11
    for (int i = 0; i < 16; i++) begin
      ts = {32'h0000_00AB, 32'(i)};
      smp(VECS[i].vld, VECS[i].trig, VECS[i].data);
      chk($sformatf("R2 vec%0d we", i), 32'(we), 32'(VECS[i].we));
      if (VECS[i].we) begin
        chk($sformatf("R3 vec%0d addr", i), 32'(addr), 32'(VECS[i].addr));
        chk($sformatf("R2 vec%0d data", i), 32'(wdat), 32'(VECS[i].data));
      end
      chk($sformatf("R8 vec%0d irq", i), 32'(irq), 32'(VECS[i].irq));
    end

    reg_rd(6'h20, rv); chk("R3 R4 win0 count+flag", rv, 32'h8000_0008);
    reg_rd(6'h21, rv); chk("R3 win0 last addr", rv, 32'h104);
    reg_rd(6'h22, rv); chk("R4 win0 ts lo", rv, 32'd11);
    reg_rd(6'h23, rv); chk("R4 win0 ts hi", rv, 32'hAB);
    reg_rd(6'h06, rv); chk("R4 cur", rv, 1);
    reg_rd(6'h07, rv); chk("R4 last", rv, 0);
    reg_wr(6'h05, 32'h1);
    chk("R8 w1c irq", 32'(irq), 0);

    // irq disabled, cycle windows 1 and 2 back to 0
    reg_wr(6'h00, 32'hD);
    smp_chk("R4 w1", 1'b1, 8'd20, 1'b1, 16'h010A);
    smp_chk("R4 w1", 1'b0, 8'd21, 1'b1, 16'h010B);
    smp_chk("R4 w1", 1'b0, 8'd22, 1'b1, 16'h010C);
    reg_rd(6'h06, rv); chk("R4 cur after w1", rv, 2);
    smp_chk("R4 w2", 1'b1, 8'd30, 1'b1, 16'h0110);
    smp_chk("R4 w2", 1'b0, 8'd31, 1'b1, 16'h0111);
    smp_chk("R4 w2", 1'b0, 8'd32, 1'b1, 16'h0112);
    reg_rd(6'h06, rv); chk("R4 modulo cur", rv, 0);
    reg_rd(6'h07, rv); chk("R4 modulo last", rv, 2);
    chk("R8 irq disabled", 32'(irq), 0);

    // R7 overwrite restart
    smp_chk("R7 w0 restart", 1'b0, 8'd40, 1'b1, 16'h0100);
    reg_rd(6'h20, rv); chk("R7 count restart", rv, 1);
    smp_chk("R7 w0", 1'b1, 8'd41, 1'b1, 16'h0101);
    smp_chk("R7 w0", 1'b0, 8'd42, 1'b1, 16'h0102);
    smp_chk("R7 w0", 1'b0, 8'd43, 1'b1, 16'h0103);

    // R6 no-overwrite hold
    reg_wr(6'h00, 32'h5);
    smp_chk("R6 held drop", 1'b0, 8'd50, 1'b0, 16'h0);
    reg_rd(6'h24, rv); chk("R6 count kept", rv, 32'h8000_0005);
    reg_wr(6'h24, 32'h0);
    reg_rd(6'h24, rv); chk("R6 count cleared", rv, 0);
    smp_chk("R6 resume", 1'b0, 8'd51, 1'b1, 16'h0108);
    reg_rd(6'h24, rv); chk("R6 count 1", rv, 1);

    // reset again: R1, R10, R5, R9
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 we", 32'(we), 0);
    reg_rd(6'h20, rv); chk("R1 count", rv, 0);
    reg_rd(6'h21, rv); chk("R1 last addr", rv, 0);
    reg_rd(6'h07, rv); chk("R1 last win", rv, 0);
    reg_wr(6'h03, 32'd0);
    reg_rd(6'h03, rv); chk("R10 clamp low", rv, 1);
    reg_wr(6'h03, 32'd9);
    reg_rd(6'h03, rv); chk("R10 clamp high", rv, 4);
    reg_wr(6'h03, 32'd2);
    reg_wr(6'h01, 32'h200);
    reg_wr(6'h02, 32'd4);
    reg_wr(6'h00, 32'hB);
    for (int k = 0; k < 4; k++) begin
      smp_chk("R5 linear", 1'b0, 8'(k), 1'b1, 16'h0200 + 16'(k));
      chk("R5 close irq", 32'(irq), (k == 3) ? 1 : 0);
    end
    reg_rd(6'h06, rv); chk("R5 cur", rv, 1);
    smp_chk("R5 next win", 1'b0, 8'd9, 1'b1, 16'h0204);
    reg_wr(6'h00, 32'hA);
    smp_chk("R9 disabled", 1'b0, 8'd10, 1'b0, 16'h0);
    reg_rd(6'h24, rv); chk("R9 count unchanged", rv, 1);

    done = 1;
    summary();
  end
endmodule